// File: doc/BRIEF.md
# Auxiliary Register Address Unit

This block generates indirect data-memory addresses from a small file of auxiliary registers. A pointer chooses one register, and that register's content is the address of the current access. In the same clock cycle the unit can post-modify the chosen register by one step up or down, or by a signed step taken from a separate index register. It can also load a new pointer value, which takes effect on the following access. Address arithmetic therefore runs in parallel with the access and needs no help from the main ALU.

A 16-bit write bus loads any auxiliary register, the pointer or the index register. A combinational read port returns any of these values so that they can be stored or used as ALU inputs. Memory, instruction decoding and bit-reversed addressing are handled outside this block.

Top module: `aru_top`

## Requirements
- R1: After reset all eight registers, the pointer and the index register read as zero.
- R2: While `acc_en` is high, `addr_vld` is high and `addr_o` equals the register selected by the current pointer. While `acc_en` is low, `addr_vld` is low and `addr_o` is zero.
- R3: On a cycle with `acc_en` high, `mod_op` post-modifies the selected register, with the result visible from the next cycle: 0 leaves it unchanged, 1 adds one, 2 subtracts one, 3 adds the index, 4 subtracts the index, and 5 to 7 leave it unchanged.
- R4: All address arithmetic wraps modulo 2^16 (0xFFFF+1 gives 0x0000, and 0x0000-1 gives 0xFFFF).
- R5: A pointer load (`ptr_ld` with `acc_en`) takes effect on the next cycle. The modification in the same cycle still applies to the register chosen by the old pointer.
- R6: A bus write (`wr_en`) with `wr_tgt` 0 to 7 loads that register. `wr_tgt` 8 loads the pointer from `wr_data[2:0]`, and `wr_tgt` 9 loads the index. Writes with `wr_tgt` 10 to 15 change nothing.
- R7: When a bus write and an auto-modify target the same register in the same cycle, the bus write wins. When a bus write to the pointer and a pointer load happen in the same cycle, the bus write wins.
- R8: An index modification uses the index value from before any index write made in the same cycle.
- R9: `rd_data` returns, without a clock delay, register `rd_tgt` for values 0 to 7, the pointer zero-extended for 8, the index for 9, and zero for 10 to 15.
- R10: While `acc_en` is low, `mod_op`, `ptr_ld` and `ptr_new` change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Indirect access this cycle |
| mod_op | input | 3 | Post-modify operation |
| ptr_ld | input | 1 | Load a new pointer with this access |
| ptr_new | input | 3 | Next pointer value |
| wr_en | input | 1 | Bus write strobe |
| wr_tgt | input | 4 | Bus write target |
| wr_data | input | 16 | Bus write data |
| rd_tgt | input | 4 | Read target |
| rd_data | output | 16 | Read data |
| addr_o | output | 16 | Memory address |
| addr_vld | output | 1 | Address valid |
| ptr_o | output | 3 | Current pointer |

## Verification
The hardest case to reach is a single cycle where an access, a pointer load, an index step and bus writes all collide. Examples are a write to the very register being modified, a write to the pointer while a pointer load is requested, and a write to the index during an index step. Directed cycles set up each collision on purpose. The random phase then draws its write targets from a narrow range and often steers them to the current pointer, so that the same collisions recur among the other operations. State that is not seen on the address output is read back through the read port during idle cycles.

// File: rtl/aru_pkg.sv
package aru_pkg;
    typedef enum logic [2:0] {
        MOD_NONE = 3'd0,
        MOD_INC  = 3'd1,
        MOD_DEC  = 3'd2,
        MOD_ADDX = 3'd3,
        MOD_SUBX = 3'd4
    } mod_op_e;
endpackage

// File: rtl/aru_step.sv
module aru_step
    import aru_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] base,
    input  logic [W-1:0] idx,
    input  logic [2:0]   op,
    output logic [W-1:0] res
);
    always_comb begin
        case (op)
            MOD_INC:  res = base + W'(1);
            MOD_DEC:  res = base - W'(1);
            MOD_ADDX: res = base + idx;
            MOD_SUBX: res = base - idx;
            default:  res = base;
        endcase
    end
endmodule

// File: rtl/aru_rdmux.sv
module aru_rdmux #(
    parameter int W  = 16,
    parameter int N  = 8,
    parameter int PW = 3,
    parameter int TW = 4
) (
    input  logic [N-1:0][W-1:0] ar,
    input  logic [PW-1:0]       ptr,
    input  logic [W-1:0]        idx,
    input  logic [TW-1:0]       tgt,
    output logic [W-1:0]        data
);
    localparam int SLOTS = 2 ** TW;
    logic [W-1:0] opts [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        if (g < N) begin : g_ar
            assign opts[g] = ar[g];
        end else if (g == N) begin : g_ptr
            assign opts[g] = W'(ptr);
        end else if (g == N + 1) begin : g_idx
            assign opts[g] = idx;
        end else begin : g_zero
            assign opts[g] = '0;
        end
    end

    assign data = opts[tgt];
endmodule

// File: rtl/aru_top.sv
module aru_top
    import aru_pkg::*;
#(
    parameter int W    = 16,
    parameter int NREG = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    acc_en,
    input  logic [2:0]              mod_op,
    input  logic                    ptr_ld,
    input  logic [$clog2(NREG)-1:0] ptr_new,
    input  logic                    wr_en,
    input  logic [3:0]              wr_tgt,
    input  logic [W-1:0]            wr_data,
    input  logic [3:0]              rd_tgt,
    output logic [W-1:0]            rd_data,
    output logic [W-1:0]            addr_o,
    output logic                    addr_vld,
    output logic [$clog2(NREG)-1:0] ptr_o
);
    localparam int PW = $clog2(NREG);
    localparam int TW = 4;
    localparam logic [TW-1:0] TGT_PTR = TW'(NREG);
    localparam logic [TW-1:0] TGT_IDX = TW'(NREG + 1);

    typedef struct packed {
        logic [NREG-1:0][W-1:0] ar;
        logic [PW-1:0]          ptr;
        logic [W-1:0]           idx;
    } st_t;

    st_t          s_d, s_q;
    logic [W-1:0] mod_val_d;
    logic [2:0]   eff_op_d;

    assign eff_op_d = acc_en ? mod_op : 3'(MOD_NONE);

    aru_step #(.W(W)) u_step (
        .base (s_q.ar[s_q.ptr]),
        .idx  (s_q.idx),
        .op   (eff_op_d),
        .res  (mod_val_d)
    );

    always_comb begin
        s_d = s_q;
        if (acc_en) begin
            s_d.ar[s_q.ptr] = mod_val_d;
            if (ptr_ld) s_d.ptr = ptr_new;
        end
        if (wr_en) begin
            if (wr_tgt < TGT_PTR)       s_d.ar[wr_tgt[PW-1:0]] = wr_data;
            else if (wr_tgt == TGT_PTR) s_d.ptr = wr_data[PW-1:0];
            else if (wr_tgt == TGT_IDX) s_d.idx = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign addr_o   = acc_en ? s_q.ar[s_q.ptr] : '0;
    assign addr_vld = acc_en;
    assign ptr_o    = s_q.ptr;

    aru_rdmux #(.W(W), .N(NREG), .PW(PW), .TW(TW)) u_rd (
        .ar   (s_q.ar),
        .ptr  (s_q.ptr),
        .idx  (s_q.idx),
        .tgt  (rd_tgt),
        .data (rd_data)
    );

    AST_PTR_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        acc_en && ptr_ld && !(wr_en && wr_tgt == TGT_PTR) |=> ptr_o == $past(ptr_new)); // R5
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_tgt < TGT_PTR |=> s_q.ar[$past(wr_tgt[PW-1:0])] == $past(wr_data)); // R7
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_en && !wr_en |=> $stable(s_q)); // R10
    AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        acc_en && mod_op == 3'(MOD_INC) && !(wr_en && wr_tgt == TW'(s_q.ptr))
        |=> s_q.ar[$past(s_q.ptr)] == W'($past(addr_o) + W'(1))); // R4
    AST_ADDR_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        acc_en && mod_op == 3'(MOD_NONE) && !wr_en && !ptr_ld ##1 acc_en
        |-> addr_o == $past(addr_o)); // R2
endmodule

// File: tb/sim_aru_top.sv
`timescale 1ns/10ps
module sim_aru_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_en = 1'b0;
    logic [2:0]  mod_op = '0;
    logic        ptr_ld = 1'b0;
    logic [2:0]  ptr_new = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_tgt = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  rd_tgt = '0;
    logic [15:0] rd_data, addr_o;
    logic        addr_vld;
    logic [2:0]  ptr_o;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [15:0] m_ar [8];
    logic [2:0]  m_ptr;
    logic [15:0] m_idx;

    always #4 clk = ~clk;

    aru_top u0 (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .mod_op(mod_op),
        .ptr_ld(ptr_ld), .ptr_new(ptr_new), .wr_en(wr_en), .wr_tgt(wr_tgt),
        .wr_data(wr_data), .rd_tgt(rd_tgt), .rd_data(rd_data),
        .addr_o(addr_o), .addr_vld(addr_vld), .ptr_o(ptr_o)
    );

    function automatic logic [15:0] step_val(logic [15:0] b, logic [15:0] x, logic [2:0] op);
        case (op)
            3'd1: return b + 16'd1;
            3'd2: return b - 16'd1;
            3'd3: return b + x;
            3'd4: return b - x;
            default: return b;
        endcase
    endfunction

    function automatic logic [15:0] exp_rd(logic [3:0] t);
        if (t < 4'd8) return m_ar[t[2:0]];
        if (t == 4'd8) return {13'd0, m_ptr};
        if (t == 4'd9) return m_idx;
        return 16'd0;
    endfunction

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One clock cycle of stimulus, output check before the edge, model update after it
    task automatic cyc(input logic a, input logic [2:0] op, input logic pl,
                       input logic [2:0] pn, input logic we, input logic [3:0] t,
                       input logic [15:0] d);
        logic [15:0] n_ar [8];
        logic [2:0]  n_ptr;
        logic [15:0] n_idx;
        @(negedge clk);
        acc_en = a; mod_op = op; ptr_ld = pl; ptr_new = pn;
        wr_en = we; wr_tgt = t; wr_data = d;
        #1;
        chk("R2 addr_vld", {15'd0, addr_vld}, {15'd0, a});
        chk("R2 addr_o", addr_o, a ? m_ar[m_ptr] : 16'd0);
        chk("R5 ptr_o", {13'd0, ptr_o}, {13'd0, m_ptr});
        n_ar = m_ar; n_ptr = m_ptr; n_idx = m_idx;
        if (a) begin
            n_ar[m_ptr] = step_val(m_ar[m_ptr], m_idx, op);
            if (pl) n_ptr = pn;
        end
        if (we) begin
            if (t < 4'd8) n_ar[t[2:0]] = d;
            else if (t == 4'd8) n_ptr = d[2:0];
            else if (t == 4'd9) n_idx = d;
        end
        @(posedge clk);
        m_ar = n_ar; m_ptr = n_ptr; m_idx = n_idx;
    endtask

    // Idle cycle that sweeps the combinational read port over every target
    task automatic sweep(string req);
        @(negedge clk);
        acc_en = 0; wr_en = 0; ptr_ld = 0; mod_op = 0;
        for (int t = 0; t < 16; t++) begin
            rd_tgt = 4'(t);
            #0.2;
            chk(req, rd_data, exp_rd(4'(t)));
        end
        @(posedge clk);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 8; i++) m_ar[i] = '0;
        m_ptr = '0; m_idx = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        sweep("R1 reset");

        // R6: load every register, index, then pointer
        for (int i = 0; i < 8; i++) cyc(0, 0, 0, 0, 1, 4'(i), 16'h1000 + 16'(i * 16'h0111));
        cyc(0, 0, 0, 0, 1, 4'd9, 16'h0005);
        cyc(0, 0, 0, 0, 1, 4'd8, 16'hFFF3);
        sweep("R6 load R9 readback");
        // R6: ignored targets
        for (int t = 10; t < 16; t++) cyc(0, 0, 0, 0, 1, 4'(t), 16'hDEAD);
        sweep("R6 ignored targets");

        // R2/R3 step modes on register 3
        cyc(1, 3'd1, 0, 0, 0, 0, 0);
        cyc(1, 3'd2, 0, 0, 0, 0, 0);
        cyc(1, 3'd3, 0, 0, 0, 0, 0);
        cyc(1, 3'd4, 0, 0, 0, 0, 0);
        cyc(1, 3'd6, 0, 0, 0, 0, 0);
        sweep("R3 step modes");

        // R4 wrap both ways
        cyc(0, 0, 0, 0, 1, 4'd3, 16'hFFFF);
        cyc(1, 3'd1, 0, 0, 0, 0, 0);
        cyc(1, 3'd2, 0, 0, 0, 0, 0);
        cyc(1, 3'd4, 0, 0, 0, 0, 0);
        sweep("R4 wrap");

        // R5 pointer load with same-cycle modify of old register
        cyc(1, 3'd1, 1, 3'd6, 0, 0, 0);
        cyc(1, 3'd2, 1, 3'd0, 0, 0, 0);
        sweep("R5 pointer change");

        // R7 write beats modify on the same register; pointer write beats pointer load
        cyc(1, 3'd1, 0, 0, 1, 4'd0, 16'h4242);
        cyc(1, 3'd1, 1, 3'd5, 1, 4'd8, 16'h0002);
        sweep("R7 priority");

        // R8 index step uses old index
        cyc(1, 3'd3, 0, 0, 1, 4'd9, 16'h0100);
        cyc(1, 3'd4, 0, 0, 1, 4'd9, 16'h0007);
        sweep("R8 index order");

        // R10 ignored without access
        cyc(0, 3'd1, 1, 3'd7, 0, 0, 0);
        cyc(0, 3'd3, 1, 3'd4, 0, 0, 0);
        sweep("R10 idle ignore");

        // Random phase with targets often aimed at collisions
        for (int k = 0; k < 400; k++) begin
            logic [3:0] t;
            t = ($urandom % 3 == 0) ? {1'b0, m_ptr} : 4'($urandom % 12);
            cyc(1'($urandom), 3'($urandom), 1'($urandom), 3'($urandom),
                ($urandom % 3) == 0, t, 16'($urandom));
            if (k % 50 == 49) sweep("R3 R7 random readback");
        end
        sweep("R9 final readback");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule